// File: doc/BRIEF.md
# Shared SRAM Bank Arbiter

Two processors, a base master and an auxiliary master, share two SRAM banks (A and B). This block decides which of them owns each bank. Both masters write its registers through one port, and each write carries a flag that says which master issued it. A master asks for a bank by setting a request bit. Hardware grants a free bank by setting the matching ownership bit, and the owner gives the bank back by clearing that bit. Grants, relinquish demands and accesses to a bank the master does not own are recorded in a sticky log for each master. The OR of each log drives that master's interrupt line.

The block has two sharing modes. In spinlock mode each bank has its own state machine, and each master asks for banks on its own behalf. In handshake mode, bank A's ownership covers both banks. A master passes both banks to its peer by setting the peer's bank A request bit. The base master uses this to say "start processing"; the auxiliary master uses it to say "data ready".

Each bank's state machine has five states:
- `BK_FREE`: no owner.
- `BK_BASE`: base master owns the bank.
- `BK_BASE_REL`: base master owns it and has been asked to give it up.
- `BK_AUX`: auxiliary master owns the bank.
- `BK_AUX_REL`: auxiliary master owns it and has been asked to give it up.

The transitions are:
- **grant**: `BK_FREE` goes to `BK_BASE` or `BK_AUX` when a request is pending.
- **demand**: `BK_BASE` goes to `BK_BASE_REL` (and `BK_AUX` to `BK_AUX_REL`) when the other master's request is pending.
- **release**: any owned state goes to `BK_FREE` when the owner clears its ownership bit.

Top module: `sram_bank_arbiter`

## Requirements
- R1: Register word addresses are:
  - 0: mode (bit 0; 1 = spinlock, 0 = handshake)
  - 1: priority (bits 1:0)
  - 2: bank A ownership
  - 3: bank B ownership
  - 4: base request for bank A
  - 5: auxiliary request for bank A
  - 6: base request for bank B
  - 7: auxiliary request for bank B
  - 8: base log
  - 9: auxiliary log

  Any other address reads 0. After reset every register reads 0 (handshake mode) and both interrupt lines are low.
- R2: Only a base-master write changes the mode and priority registers. Writes to them from the auxiliary master are ignored.
- R3: Ownership bits are set only by a grant: bit 0 means the base master owns the bank, bit 1 means the auxiliary master owns it. Writing 1 to bit 0 clears it only when the base master writes it. Writing 1 to bit 1 clears it only when the auxiliary master writes it. Writing a clear to a bit that is not set has no effect.
- R4: In spinlock mode, a master sets its own request bit for a bank by writing 1 to bit 0. When the bank is free, the bank is granted on the clock edge after the request is registered, and the request bit is cleared on that same edge.
- R5: A grant sets a grant bit in the new owner's log:
  - base log: bit 1 for bank A, bit 2 for bank B
  - auxiliary log: bit 0 for bank A, bit 1 for bank B
- R6: When both requests are pending on a free bank, the priority field decides the winner:
  - 01: the auxiliary master wins.
  - 10: the base master wins.
  - 00 or 11: a per-bank round-robin pointer decides. It starts at the base master and toggles after each contested grant made under these codes.
- R7: A request against a bank held by the other master sets the holder's relinquish log bit:
  - base log: bit 3 for bank A, bit 4 for bank B
  - auxiliary log: bit 2 for bank A, bit 3 for bank B

  The request is granted only after the holder clears its ownership bit.
- R8: An access strobe on a bank that the master does not currently own sets base log bit 0 (base master) or auxiliary log bit 4 (auxiliary master).
- R9: Each interrupt line is the OR of its master's log bits. Writing 1 to a log bit clears it, but only when the log's own master writes it. A hardware set in the same cycle takes precedence over the clear.
- R10: In handshake mode:
  - Bank A ownership governs access checks for both banks.
  - Only the base master sets the auxiliary bank A request, and only the auxiliary master sets the base bank A request.
  - Writes to the bank B request registers, and a master's write to its own bank A request, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_aux | input | 1 | Writer identity: 1 = auxiliary master, 0 = base master |
| reg_addr | input | ADDR_W | Register word address for writes |
| reg_wdata | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Register word address for reads |
| rd_data | output | DATA_W | Read data (combinational) |
| base_acc | input | 2 | Base master access strobe for each bank (bit 0 = A) |
| aux_acc | input | 2 | Auxiliary master access strobe for each bank (bit 0 = A) |
| base_irq | output | 1 | Base master interrupt |
| aux_irq | output | 1 | Auxiliary master interrupt |

## Verification
The assertions check the following on every cycle:
- Ownership of bank A persists until its owner clears it.
- A new owner always had a pending request.
- Grants and invalid accesses reach the log on the next edge.
- The mode register stays unchanged when the auxiliary master writes to it.

The bench scenarios show the parts of the behaviour that depend on ordering:
- the outcome of a contest under each priority code;
- the round-robin pointer alternating across successive contests;
- the relinquish-then-grant sequence;
- the handshake-mode transfers, in which bank A's owner also covers bank B.

// File: rtl/sab_pkg.sv
package sab_pkg;

    localparam int NUM_BANKS = 2;
    localparam int LOG_W     = 5;

    // register word indices
    localparam int REG_MODE     = 0;
    localparam int REG_PRIO     = 1;
    localparam int REG_OWN0     = 2;  // + bank
    localparam int REG_REQ_BASE = 4;  // + 2*bank
    localparam int REG_REQ_AUX  = 5;  // + 2*bank
    localparam int REG_LOG_BASE = 8;
    localparam int REG_LOG_AUX  = 9;

    typedef enum logic [2:0] {
        BK_FREE,
        BK_BASE,
        BK_BASE_REL,
        BK_AUX,
        BK_AUX_REL
    } bank_state_e;

    typedef enum logic [1:0] {
        PRIO_EQUAL = 2'b00,
        PRIO_AUX   = 2'b01,
        PRIO_BASE  = 2'b10,
        PRIO_SPARE = 2'b11
    } prio_e;

endpackage

// File: rtl/sab_event_log.sv
module sab_event_log #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] log_o,
    output logic         irq_o
);
    logic [W-1:0] log_q;

    // hardware set wins over a software clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) log_q <= '0;
        else        log_q <= (log_q & ~clr_i) | set_i;
    end

    assign log_o = log_q;
    assign irq_o = |log_q;
endmodule

// File: rtl/sab_bank_fsm.sv
module sab_bank_fsm
    import sab_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] prio,
    input  logic       req_base,
    input  logic       req_aux,
    input  logic       clr_base,
    input  logic       clr_aux,
    output logic       own_base,
    output logic       own_aux,
    output logic       gnt_base,
    output logic       gnt_aux,
    output logic       rel_base,
    output logic       rel_aux
);
    bank_state_e state_q, state_d;
    logic        rr_q, rr_d;      // 1: auxiliary master wins the next tie
    logic        tie_mode, contested, aux_wins;

    assign tie_mode  = (prio == PRIO_EQUAL) || (prio == PRIO_SPARE);
    assign contested = req_base && req_aux;
    assign aux_wins  = req_aux && (!req_base || (prio == PRIO_AUX) || (tie_mode && rr_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_FREE;
            rr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            rr_q    <= rr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rr_d    = rr_q;
        unique case (state_q)
            BK_FREE: begin
                if (enable && (req_base || req_aux)) begin
                    state_d = aux_wins ? BK_AUX : BK_BASE;
                    if (contested && tie_mode) rr_d = ~rr_q;
                end
            end
            BK_BASE: begin
                if (clr_base)                state_d = BK_FREE;
                else if (enable && req_aux)  state_d = BK_BASE_REL;
            end
            BK_BASE_REL: begin
                if (clr_base) state_d = BK_FREE;
            end
            BK_AUX: begin
                if (clr_aux)                 state_d = BK_FREE;
                else if (enable && req_base) state_d = BK_AUX_REL;
            end
            BK_AUX_REL: begin
                if (clr_aux) state_d = BK_FREE;
            end
            default: state_d = BK_FREE;
        endcase
    end

    always_comb begin
        own_base = (state_q == BK_BASE) || (state_q == BK_BASE_REL);
        own_aux  = (state_q == BK_AUX)  || (state_q == BK_AUX_REL);
        gnt_base = (state_q == BK_FREE) && enable && req_base && !aux_wins;
        gnt_aux  = (state_q == BK_FREE) && enable && aux_wins;
        rel_base = (state_q == BK_BASE) && enable && req_aux  && !clr_base;
        rel_aux  = (state_q == BK_AUX)  && enable && req_base && !clr_aux;
    end
endmodule

// File: rtl/sram_bank_arbiter.sv
module sram_bank_arbiter
    import sab_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_wr_aux,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [1:0]        base_acc,
    input  logic [1:0]        aux_acc,
    output logic              base_irq,
    output logic              aux_irq
);
    logic                 wr_base, wr_aux;
    logic                 mode_q;   // 1 = spinlock
    logic [1:0]           prio_q;
    logic [NUM_BANKS-1:0] req_base_q, req_aux_q;
    logic [NUM_BANKS-1:0] req_base_set, req_aux_set;
    logic [NUM_BANKS-1:0] clr_base, clr_aux;
    logic [NUM_BANKS-1:0] own_base, own_aux, gnt_base, gnt_aux, rel_base, rel_aux;
    logic [NUM_BANKS-1:0] eff_base, eff_aux;
    logic                 base_bad, aux_bad;
    logic [LOG_W-1:0]     base_log, aux_log, base_set, aux_set, base_clr, aux_clr;
    logic                 unused_wdata;

    assign wr_base      = reg_wr_en && !reg_wr_aux;
    assign wr_aux       = reg_wr_en &&  reg_wr_aux;
    assign unused_wdata = ^reg_wdata[DATA_W-1:LOG_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            prio_q <= 2'b00;
        end else if (wr_base) begin
            if (reg_addr == ADDR_W'(REG_MODE)) mode_q <= reg_wdata[0];
            if (reg_addr == ADDR_W'(REG_PRIO)) prio_q <= reg_wdata[1:0];
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int OWN_IX  = REG_OWN0 + b;
        localparam int RQB_IX  = REG_REQ_BASE + 2 * b;
        localparam int RQA_IX  = REG_REQ_AUX + 2 * b;
        localparam bit IS_BANK0 = (b == 0);
        logic bank_en;

        // in handshake mode only bank A runs, and each request is set by the peer
        assign req_base_set[b] = reg_wdata[0] && (reg_addr == ADDR_W'(RQB_IX)) &&
                                 ((mode_q && wr_base) || (!mode_q && IS_BANK0 && wr_aux));
        assign req_aux_set[b]  = reg_wdata[0] && (reg_addr == ADDR_W'(RQA_IX)) &&
                                 ((mode_q && wr_aux) || (!mode_q && IS_BANK0 && wr_base));
        assign clr_base[b]     = wr_base && (reg_addr == ADDR_W'(OWN_IX)) && reg_wdata[0];
        assign clr_aux[b]      = wr_aux  && (reg_addr == ADDR_W'(OWN_IX)) && reg_wdata[1];
        assign bank_en         = IS_BANK0 ? 1'b1 : mode_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_base_q[b] <= 1'b0;
                req_aux_q[b]  <= 1'b0;
            end else begin
                req_base_q[b] <= (req_base_q[b] && !gnt_base[b]) || req_base_set[b];
                req_aux_q[b]  <= (req_aux_q[b]  && !gnt_aux[b])  || req_aux_set[b];
            end
        end

        sab_bank_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (bank_en),
            .prio     (prio_q),
            .req_base (req_base_q[b]),
            .req_aux  (req_aux_q[b]),
            .clr_base (clr_base[b]),
            .clr_aux  (clr_aux[b]),
            .own_base (own_base[b]),
            .own_aux  (own_aux[b]),
            .gnt_base (gnt_base[b]),
            .gnt_aux  (gnt_aux[b]),
            .rel_base (rel_base[b]),
            .rel_aux  (rel_aux[b])
        );

        assign eff_base[b] = (mode_q || IS_BANK0) ? own_base[b] : own_base[0];
        assign eff_aux[b]  = (mode_q || IS_BANK0) ? own_aux[b]  : own_aux[0];
    end

    assign base_bad = |(base_acc & ~eff_base);
    assign aux_bad  = |(aux_acc  & ~eff_aux);

    assign base_set = {rel_base[1], rel_base[0], gnt_base[1], gnt_base[0], base_bad};
    assign aux_set  = {aux_bad, rel_aux[1], rel_aux[0], gnt_aux[1], gnt_aux[0]};
    assign base_clr = (wr_base && reg_addr == ADDR_W'(REG_LOG_BASE)) ? reg_wdata[LOG_W-1:0] : '0;
    assign aux_clr  = (wr_aux  && reg_addr == ADDR_W'(REG_LOG_AUX))  ? reg_wdata[LOG_W-1:0] : '0;

    sab_event_log #(.W(LOG_W)) u_base_log (
        .clk(clk), .rst_n(rst_n), .set_i(base_set), .clr_i(base_clr),
        .log_o(base_log), .irq_o(base_irq)
    );

    sab_event_log #(.W(LOG_W)) u_aux_log (
        .clk(clk), .rst_n(rst_n), .set_i(aux_set), .clr_i(aux_clr),
        .log_o(aux_log), .irq_o(aux_irq)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(REG_MODE))     rd_data[0]       = mode_q;
        if (rd_addr == ADDR_W'(REG_PRIO))     rd_data[1:0]     = prio_q;
        if (rd_addr == ADDR_W'(REG_LOG_BASE)) rd_data[LOG_W-1:0] = base_log;
        if (rd_addr == ADDR_W'(REG_LOG_AUX))  rd_data[LOG_W-1:0] = aux_log;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rd_addr == ADDR_W'(REG_OWN0 + b))         rd_data[1:0] = {own_aux[b], own_base[b]};
            if (rd_addr == ADDR_W'(REG_REQ_BASE + 2 * b)) rd_data[0]   = req_base_q[b];
            if (rd_addr == ADDR_W'(REG_REQ_AUX + 2 * b))  rd_data[0]   = req_aux_q[b];
        end
    end
endmodule

// File: rtl/sab_checker.sv
module sab_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic              reg_wr_aux,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              mode_q,
    input logic [1:0]        own_base,
    input logic [1:0]        own_aux,
    input logic [1:0]        req_base,
    input logic [1:0]        req_aux,
    input logic [1:0]        clr_base,
    input logic [1:0]        clr_aux,
    input logic [1:0]        base_acc,
    input logic [1:0]        eff_base,
    input logic [4:0]        base_log,
    input logic [4:0]        aux_log
);
    // R2
    a_r2_mode_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_aux && reg_addr == '0) |=> $stable(mode_q));

    // R3
    a_r3_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (own_base[0] && !clr_base[0]) |=> own_base[0]);

    // R3
    a_r3_aux_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (own_aux[0] && !clr_aux[0]) |=> own_aux[0]);

    // R4
    a_r4_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_base[0]) |-> $past(req_base[0]));

    // R4
    a_r4_aux_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_aux[1]) |-> $past(req_aux[1]));

    // R5
    a_r5_grant_logged: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_aux[0]) |-> aux_log[0]);

    // R8
    a_r8_invalid_logged: assert property (@(posedge clk) disable iff (!rst_n)
        (base_acc[0] && !eff_base[0]) |=> base_log[0]);
endmodule

bind sram_bank_arbiter sab_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_wr_aux (reg_wr_aux),
    .reg_addr   (reg_addr),
    .mode_q     (mode_q),
    .own_base   (own_base),
    .own_aux    (own_aux),
    .req_base   (req_base_q),
    .req_aux    (req_aux_q),
    .clr_base   (clr_base),
    .clr_aux    (clr_aux),
    .base_acc   (base_acc),
    .eff_base   (eff_base),
    .base_log   (base_log),
    .aux_log    (aux_log)
);

// File: tb/sram_bank_arbiter_tb_top.sv
module sram_bank_arbiter_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr_en;
    logic       reg_wr_aux;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] base_acc;
    logic [1:0] aux_acc;
    logic       base_irq, aux_irq;

    always #2 clk = ~clk;

    sram_bank_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_aux(reg_wr_aux),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .base_acc(base_acc), .aux_acc(aux_acc), .base_irq(base_irq), .aux_irq(aux_irq)
    );

    typedef struct {
        int         kind;   // 0 register read, 1 interrupt pair {aux,base}
        logic [3:0] addr;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sbq[$];
    int    pending = 0;
    int    n_chk   = 0;
    int    n_fail  = 0;
    bit    done    = 0;

    // monitor: pops expected items and compares against the design
    always @(negedge clk) begin : mon
        item_t      it;
        logic [7:0] act;
        while (sbq.size() > 0) begin
            it = sbq.pop_front();
            if (it.kind == 0) begin
                rd_addr = it.addr;
                #0.2;
                act = rd_data;
            end else begin
                act = {6'b0, aux_irq, base_irq};
            end
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
            pending--;
        end
    end

    task automatic push_exp(input int kind, input logic [3:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
        sbq.push_back(it);
        pending++;
        wait (pending == 0);
    endtask

    task automatic chk_reg(input logic [3:0] a, input logic [7:0] e, input string tag);
        push_exp(0, a, e, tag);
    endtask

    task automatic chk_irq(input logic [1:0] e, input string tag);
        push_exp(1, 4'd0, {6'b0, e}, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit aux, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_aux = aux; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic strobe(input bit aux, input int b);
        @(negedge clk);
        if (aux) aux_acc[b] = 1'b1; else base_acc[b] = 1'b1;
        @(negedge clk);
        base_acc = '0; aux_acc = '0;
    endtask

    // contest on bank B: both requests pending when the bank becomes free
    task automatic contest(input logic [1:0] p, input bit aux_wins, input string tag);
        wr(0, 4'd1, {6'b0, p});
        wr(0, 4'd6, 8'h01);
        idle(3);
        wr(0, 4'd6, 8'h01);
        wr(1, 4'd7, 8'h01);
        idle(2);
        wr(0, 4'd3, 8'h01);
        idle(3);
        chk_reg(4'd3, aux_wins ? 8'h02 : 8'h01, tag);
        if (aux_wins) begin
            wr(1, 4'd3, 8'h02); idle(3); wr(0, 4'd3, 8'h01);
        end else begin
            wr(0, 4'd3, 8'h01); idle(3); wr(1, 4'd3, 8'h02);
        end
        idle(3);
        wr(0, 4'd8, 8'h1F);
        wr(1, 4'd9, 8'h1F);
        idle(2);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : drv
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_aux = 1'b0;
        reg_addr = '0; reg_wdata = '0; base_acc = '0; aux_acc = '0;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        chk_reg(4'd0, 8'h00, "R1 mode after reset");
        chk_reg(4'd2, 8'h00, "R1 bank A ownership after reset");
        chk_reg(4'd8, 8'h00, "R1 base log after reset");
        chk_irq(2'b00, "R1 interrupts after reset");
        chk_reg(4'd12, 8'h00, "R1 unmapped address");

        wr(1, 4'd0, 8'h01);
        chk_reg(4'd0, 8'h00, "R2 aux write to mode ignored");
        wr(1, 4'd1, 8'h02);
        chk_reg(4'd1, 8'h00, "R2 aux write to priority ignored");
        wr(0, 4'd0, 8'h01);
        chk_reg(4'd0, 8'h01, "R2 base sets spinlock mode");

        wr(0, 4'd4, 8'h01);
        idle(3);
        chk_reg(4'd2, 8'h01, "R4 base granted bank A");
        chk_reg(4'd4, 8'h00, "R4 request cleared on grant");
        chk_reg(4'd8, 8'h02, "R5 base grant log bank A");
        chk_irq(2'b01, "R9 base interrupt raised");

        wr(0, 4'd8, 8'h02);
        idle(2);
        chk_irq(2'b00, "R9 log clear drops interrupt");

        wr(1, 4'd2, 8'h01);
        idle(2);
        chk_reg(4'd2, 8'h01, "R3 aux cannot clear base ownership");
        wr(1, 4'd3, 8'h02);
        idle(2);
        chk_reg(4'd3, 8'h00, "R3 clear of unowned bank has no effect");

        wr(1, 4'd5, 8'h01);
        idle(3);
        chk_reg(4'd8, 8'h08, "R7 base relinquish log bank A");
        chk_reg(4'd2, 8'h01, "R7 no grant before release");
        chk_irq(2'b01, "R7 relinquish interrupt to base");
        wr(0, 4'd2, 8'h01);
        idle(3);
        chk_reg(4'd2, 8'h02, "R7 aux granted after release");
        chk_reg(4'd9, 8'h01, "R5 aux grant log bank A");
        chk_reg(4'd5, 8'h00, "R4 aux request cleared on grant");

        strobe(0, 0);
        idle(1);
        chk_reg(4'd8, 8'h09, "R8 base invalid access logged");
        strobe(1, 0);
        idle(1);
        chk_reg(4'd9, 8'h01, "R8 aux valid access not logged");
        strobe(1, 1);
        idle(1);
        chk_reg(4'd9, 8'h11, "R8 aux invalid access bank B logged");
        chk_irq(2'b11, "R9 both interrupts raised");

        wr(0, 4'd9, 8'h1F);
        idle(2);
        chk_reg(4'd9, 8'h11, "R9 base cannot clear aux log");
        wr(1, 4'd2, 8'h02);
        wr(0, 4'd8, 8'h1F);
        wr(1, 4'd9, 8'h1F);
        idle(2);
        chk_irq(2'b00, "R9 all logs cleared");
        chk_reg(4'd2, 8'h00, "R3 aux released bank A");

        contest(2'b01, 1'b1, "R6 priority 01 aux wins");
        contest(2'b10, 1'b0, "R6 priority 10 base wins");
        contest(2'b00, 1'b0, "R6 equal first tie base");
        contest(2'b00, 1'b1, "R6 equal second tie aux");
        contest(2'b11, 1'b0, "R6 code 11 acts as equal");
        chk_reg(4'd3, 8'h00, "R3 bank B free after contests");

        wr(0, 4'd0, 8'h00);
        chk_reg(4'd0, 8'h00, "R10 handshake mode set");
        wr(0, 4'd5, 8'h01);
        idle(3);
        chk_reg(4'd2, 8'h02, "R10 base hands banks to aux");
        chk_reg(4'd9, 8'h01, "R10 aux grant logged");
        strobe(1, 1);
        idle(1);
        chk_reg(4'd9, 8'h01, "R10 bank B covered by bank A owner");
        wr(0, 4'd4, 8'h01);
        idle(2);
        chk_reg(4'd4, 8'h00, "R10 base own request write ignored");
        wr(0, 4'd6, 8'h01);
        idle(2);
        chk_reg(4'd6, 8'h00, "R10 bank B request ignored");
        wr(1, 4'd4, 8'h01);
        idle(3);
        chk_reg(4'd9, 8'h05, "R10 aux asked to relinquish");
        wr(1, 4'd2, 8'h02);
        idle(3);
        chk_reg(4'd2, 8'h01, "R10 base granted after aux release");
        chk_reg(4'd8, 8'h02, "R10 base grant logged");
        strobe(0, 1);
        idle(1);
        chk_reg(4'd8, 8'h02, "R10 base access bank B valid");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule